// File: doc/BRIEF.md
# Three-Port Parallel I/O Peripheral

This peripheral hangs off a byte-wide host bus and presents twenty-four general-purpose lines as three 8-bit ports, called A, B and C. Port C is treated as two independent 4-bit halves. Direction is set per group. The first group is port A together with the upper half of C. The second group is port B together with the lower half of C. Each port drives separate input, output and output-enable vectors, so pad tri-stating is left to the chip top.

A host access is qualified by a select strobe and by a read or a write strobe. A 2-bit register address picks one of four registers. A write to the control register is decoded in one of two formats, chosen by its most significant bit.
- With that bit set, the word is a configuration word. It sets the direction of all four port sections.
- With that bit clear, the word is a single-bit command. It sets or clears exactly one port C line in a single write, without disturbing the rest of the port.

Only simple level I/O is supported. Output values sit in latches until they are rewritten. Input values are passed straight from the pins to the read data.

Top module: `pio_triport`

## Requirements
- R1: After a synchronous active-low reset every port is an input, every output-enable bit is 0, every output latch is 0x00, and the control register reads 0x9B.
- R2: The register address selects the register as follows: 0 selects port A, 1 selects port B, 2 selects port C and 3 selects the control register.
- R3: A control write with bit 7 = 1 is a configuration word, and 1 in a direction bit means input.
  - Bit 4 sets the direction of port A, bit 3 the upper half of C, bit 1 port B and bit 0 the lower half of C.
  - Each output-enable bit is 1 exactly when its section is an output.
  - 0x82 makes A and C outputs and B an input. 0x98 makes A and the upper half of C inputs, and B and the lower half of C outputs.
- R4: A configuration word clears all three output latches to 0x00 on the same clock edge.
- R5: A control write with bit 7 = 0 is a single-bit command. Bits 3..1 give the port C bit index and bit 0 gives the new value (1 sets, 0 clears). No other port C bit changes, and neither the directions nor the control readback change.
- R6: A write to a port register loads that port's output latch. The value stays on the output vector until it is rewritten, and reading a port configured as output returns the latch.
- R7: Reading a port configured as input returns the live pin value of the current cycle, with no latching.
- R8: A read of port C takes each 4-bit half from the pins when that half is an input and from the latch when it is an output.
- R9: Reading the control register returns the last configuration word exactly as it was written. Bits 6, 5 and 2 are stored but have no effect on the ports, so 0xFF behaves like 0x9B.
- R10: Without the select strobe, a write strobe changes nothing. Read data is 0x00 unless both select and read are asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access select |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The assertions check the following on every cycle:
- A configuration word zeroes the latches.
- A single-bit command disturbs neither the other port C bits nor the directions.
- Latches and enables hold whenever no qualifying write occurs.

The bench has to show the rest:
- the decoding of each direction bit;
- the address map;
- the per-half merge of pins and latch on port C reads;
- the fact that an input read follows the pins within the same cycle.

To cover these, it sweeps all sixteen direction combinations and every bit-command index in both polarities.

// File: rtl/pio_pkg.sv
// Package: shared types and constants for the three-port parallel I/O block.
// Assumes an 8-bit control word layout; the port width is set in the modules.
package pio_pkg;

    // Register address decoding
    typedef enum logic [1:0] {
        REG_PA   = 2'b00,
        REG_PB   = 2'b01,
        REG_PC   = 2'b10,
        REG_CTRL = 2'b11
    } reg_sel_e;

    // Direction of the four port sections, 1 = input
    typedef struct packed {
        logic a_in;
        logic cu_in;
        logic b_in;
        logic cl_in;
    } port_dir_t;

    // Control readback after reset: configuration flag plus all four sections as inputs
    localparam logic [7:0] CTRL_RESET = 8'h9B;

    // Bit positions inside a configuration word
    localparam int CFG_FLAG_BIT = 7;
    localparam int DIR_A_BIT    = 4;
    localparam int DIR_CU_BIT   = 3;
    localparam int DIR_B_BIT    = 1;
    localparam int DIR_CL_BIT   = 0;

endpackage

// File: rtl/pio_ctrl.sv
// Module: pio_ctrl
// Decodes writes to the control register. A word with the flag bit set is
// stored as the configuration: it sets the directions and raises a clear pulse
// for the latches. A word with the flag bit clear becomes a single port C bit
// command (index and value). Assumes at most one write per cycle.
module pio_ctrl
    import pio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic [W-1:0]         wdata,
    output port_dir_t            dir,
    output logic [W-1:0]         ctrl_q,
    output logic                 cfg_clr,
    output logic                 bit_en,
    output logic [$clog2(W)-1:0] bit_idx,
    output logic                 bit_val
);
    localparam int SEL_W = $clog2(W);

    // Split a control write into its two formats
    always_comb begin
        cfg_clr = ctrl_wr &  wdata[CFG_FLAG_BIT];
        bit_en  = ctrl_wr & ~wdata[CFG_FLAG_BIT];
        bit_idx = wdata[SEL_W:1];
        bit_val = wdata[0];
    end

    // Hold the configuration word and the directions it implies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= W'(CTRL_RESET);
            dir    <= '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};
        end else if (cfg_clr) begin
            ctrl_q    <= wdata;
            dir.a_in  <= wdata[DIR_A_BIT];
            dir.cu_in <= wdata[DIR_CU_BIT];
            dir.b_in  <= wdata[DIR_B_BIT];
            dir.cl_in <= wdata[DIR_CL_BIT];
        end
    end

    // R9
    cfg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clr |=> ctrl_q == $past(wdata));

    // R5
    bitcmd_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> $stable(dir) && $stable(ctrl_q));

endmodule

// File: rtl/pio_port_reg.sv
// Module: pio_port_reg
// One output latch for a port. Priority: clear, then full write, then single-bit
// update. Assumes the three requests come from distinct register addresses, so
// they never coincide in practice.
module pio_port_reg #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [W-1:0]         wr_data,
    input  logic                 bit_en,
    input  logic [$clog2(W)-1:0] bit_idx,
    input  logic                 bit_val,
    output logic [W-1:0]         q
);
    // Latch update by clear, full write or single-bit command
    always_ff @(posedge clk) begin
        if (!rst_n)      q          <= '0;
        else if (clr)    q          <= '0;
        else if (wr_en)  q          <= wr_data;
        else if (bit_en) q[bit_idx] <= bit_val;
    end

    // R4
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q == '0);

    // R5
    single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !clr && !wr_en) |=> ((q ^ $past(q)) & ~(W'(1) << $past(bit_idx))) == '0);

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr || wr_en || bit_en) |=> $stable(q));

endmodule

// File: rtl/pio_read_mux.sv
// Module: pio_read_mux
// Builds the read data. Output sections return their latch and input sections
// return the live pins; port C is merged half by half. The result is zero when
// no read is in progress.
module pio_read_mux
    import pio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         rd_act,
    input  logic [1:0]   addr,
    input  port_dir_t    dir,
    input  logic [W-1:0] lat_a,
    input  logic [W-1:0] lat_b,
    input  logic [W-1:0] lat_c,
    input  logic [W-1:0] pin_a,
    input  logic [W-1:0] pin_b,
    input  logic [W-1:0] pin_c,
    input  logic [W-1:0] ctrl_q,
    output logic [W-1:0] rdata
);
    localparam int H = W / 2;

    // Pick the addressed source and merge pins with latches by direction
    always_comb begin
        rdata = '0;
        if (rd_act) begin
            unique case (reg_sel_e'(addr))
                REG_PA:   rdata = dir.a_in ? pin_a : lat_a;
                REG_PB:   rdata = dir.b_in ? pin_b : lat_b;
                REG_PC:   rdata = {(dir.cu_in ? pin_c[W-1:H] : lat_c[W-1:H]),
                                   (dir.cl_in ? pin_c[H-1:0] : lat_c[H-1:0])};
                REG_CTRL: rdata = ctrl_q;
                default:  rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pio_triport.sv
// Module: pio_triport
// Top of the three-port parallel I/O block. It decodes bus accesses, holds the
// three output latches (generated), drives the enables from the directions and
// returns read data. Assumes a synchronous host: writes take effect on the
// rising edge at which the select and write strobes are sampled high.
module pio_triport
    import pio_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_sel,
    input  logic         bus_rd,
    input  logic         bus_wr,
    input  logic [1:0]   bus_addr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pa_in,
    output logic [W-1:0] pa_out,
    output logic [W-1:0] pa_oe,
    input  logic [W-1:0] pb_in,
    output logic [W-1:0] pb_out,
    output logic [W-1:0] pb_oe,
    input  logic [W-1:0] pc_in,
    output logic [W-1:0] pc_out,
    output logic [W-1:0] pc_oe
);
    localparam int NPORT = 3;
    localparam int H     = W / 2;
    localparam int SEL_W = $clog2(W);

    logic             wr_act;
    logic             ctrl_wr;
    logic [NPORT-1:0] port_wr;
    port_dir_t        dir;
    logic [W-1:0]     ctrl_q;
    logic             cfg_clr;
    logic             bit_en;
    logic [SEL_W-1:0] bit_idx;
    logic             bit_val;
    logic [W-1:0]     lat [NPORT];

    // Decode the addressed write target
    always_comb begin
        wr_act  = bus_sel & bus_wr;
        ctrl_wr = wr_act & (bus_addr == REG_CTRL);
        for (int i = 0; i < NPORT; i++)
            port_wr[i] = wr_act & (bus_addr == 2'(i));
    end

    pio_ctrl #(.W(W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .wdata   (bus_wdata),
        .dir     (dir),
        .ctrl_q  (ctrl_q),
        .cfg_clr (cfg_clr),
        .bit_en  (bit_en),
        .bit_idx (bit_idx),
        .bit_val (bit_val)
    );

    // One latch per port; only port C takes single-bit commands
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam bit HAS_BITCMD = (p == int'(REG_PC));
        pio_port_reg #(.W(W)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (cfg_clr),
            .wr_en   (port_wr[p]),
            .wr_data (bus_wdata),
            .bit_en  (HAS_BITCMD ? bit_en : 1'b0),
            .bit_idx (bit_idx),
            .bit_val (bit_val),
            .q       (lat[p])
        );
    end

    // Drive latches and enables to the pads
    always_comb begin
        pa_out = lat[0];
        pb_out = lat[1];
        pc_out = lat[2];
        pa_oe  = {W{~dir.a_in}};
        pb_oe  = {W{~dir.b_in}};
        pc_oe  = {{H{~dir.cu_in}}, {H{~dir.cl_in}}};
    end

    pio_read_mux #(.W(W)) u_rmux (
        .rd_act (bus_sel & bus_rd),
        .addr   (bus_addr),
        .dir    (dir),
        .lat_a  (lat[0]),
        .lat_b  (lat[1]),
        .lat_c  (lat[2]),
        .pin_a  (pa_in),
        .pin_b  (pb_in),
        .pin_c  (pc_in),
        .ctrl_q (ctrl_q),
        .rdata  (bus_rdata)
    );

    // R3
    oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == 2'b11 && bus_wdata[W-1])
        |=> $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe));

    // R10
    no_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> $stable(pa_out) && $stable(pb_out) && $stable(pc_out));

endmodule

// File: tb/pio_triport_bench.sv
module pio_triport_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_sel, bus_rd, bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic [7:0] pa_in, pa_out, pa_oe;
    logic [7:0] pb_in, pb_out, pb_oe;
    logic [7:0] pc_in, pc_out, pc_oe;
    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pio_triport u_pio_triport (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0; bus_rd = 1'b0;
        #1;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, w, da, db, dc, expc, shadow;
        rst_n = 1'b0; bus_sel = 0; bus_rd = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        pa_in = 8'h00; pb_in = 8'h00; pc_in = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 pa_oe", pa_oe, 8'h00);
        chk("R1 pb_oe", pb_oe, 8'h00);
        chk("R1 pc_oe", pc_oe, 8'h00);
        chk("R1 latches", pa_out | pb_out | pc_out, 8'h00);
        rd(2'd3, r); chk("R1 ctrl readback", r, 8'h9B);

        // R2 R3 R4 R6 R7 R8 R9: sweep all sixteen direction combinations
        for (int k = 0; k < 16; k++) begin
            wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
            w = 8'h80 | {3'b000, k[3], k[2], 1'b0, k[1], k[0]} | ((k % 3 == 0) ? 8'h64 : 8'h00);
            wr(2'd3, w);
            chk("R3 pa_oe", pa_oe, k[3] ? 8'h00 : 8'hFF);
            chk("R3 pb_oe", pb_oe, k[1] ? 8'h00 : 8'hFF);
            chk("R3 pc_oe", pc_oe, {(k[2] ? 4'h0 : 4'hF), (k[0] ? 4'h0 : 4'hF)});
            chk("R4 cleared latches", pa_out | pb_out | pc_out, 8'h00);
            rd(2'd3, r); chk("R9 ctrl readback", r, w);
            da = (8'h11 * k[7:0]) ^ 8'hA5; db = ~da; dc = {k[3:0], ~k[3:0]};
            wr(2'd0, da); wr(2'd1, db); wr(2'd2, dc);
            repeat (2) @(negedge clk);
            chk("R6 pa_out hold", pa_out, da);
            chk("R6 pb_out hold", pb_out, db);
            chk("R6 pc_out hold", pc_out, dc);
            pa_in = 8'h3C ^ k[7:0]; pb_in = 8'hC3 ^ k[7:0]; pc_in = 8'h96 + k[7:0];
            for (int pass = 0; pass < 2; pass++) begin
                rd(2'd0, r); chk("R2 R7 read port A", r, k[3] ? pa_in : da);
                rd(2'd1, r); chk("R2 R7 read port B", r, k[1] ? pb_in : db);
                expc = {(k[2] ? pc_in[7:4] : dc[7:4]), (k[0] ? pc_in[3:0] : dc[3:0])};
                rd(2'd2, r); chk("R8 read port C", r, expc);
                pa_in = ~pa_in; pb_in = ~pb_in; pc_in = ~pc_in;
            end
        end

        // R3 named words
        wr(2'd3, 8'h82);
        chk("R3 0x82 pa_oe", pa_oe, 8'hFF); chk("R3 0x82 pb_oe", pb_oe, 8'h00); chk("R3 0x82 pc_oe", pc_oe, 8'hFF);
        wr(2'd3, 8'h98);
        chk("R3 0x98 pa_oe", pa_oe, 8'h00); chk("R3 0x98 pb_oe", pb_oe, 8'hFF); chk("R3 0x98 pc_oe", pc_oe, 8'h0F);
        // R9 mode bits ignored
        wr(2'd3, 8'hFF);
        chk("R9 0xFF acts as all inputs", pa_oe | pb_oe | pc_oe, 8'h00);

        // R5 single-bit commands over every index, both polarities
        wr(2'd3, 8'h80);
        for (int start = 0; start < 2; start++) begin
            shadow = start ? 8'hA5 : 8'h00;
            wr(2'd2, shadow);
            for (int b = 0; b < 8; b++) begin
                wr(2'd3, {4'b0000, 3'(b), 1'b1}); shadow[b] = 1'b1;
                chk("R5 set bit", pc_out, shadow);
            end
            for (int b = 0; b < 8; b++) begin
                wr(2'd3, {4'b0000, 3'(7 - b), 1'b0}); shadow[7 - b] = 1'b0;
                chk("R5 clear bit", pc_out, shadow);
                wr(2'd3, {4'b0000, 3'(b), start[0]}); shadow[b] = start[0];
                chk("R5 toggle bit", pc_out, shadow);
            end
            chk("R5 directions kept", pa_oe & pb_oe & pc_oe, 8'hFF);
            rd(2'd3, r); chk("R5 ctrl readback kept", r, 8'h80);
        end

        // R10 unselected accesses have no effect
        wr(2'd0, 8'h5A);
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h77;
        @(negedge clk); bus_wr = 1'b0;
        chk("R10 write without select", pa_out, 8'h5A);
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h9B;
        @(negedge clk); bus_wr = 1'b0;
        chk("R10 ctrl write without select", pa_oe, 8'hFF);
        bus_rd = 1'b1; bus_addr = 2'd3; #1;
        chk("R10 read without select", bus_rdata, 8'h00);
        bus_rd = 1'b0; bus_sel = 1'b1; #1;
        chk("R10 select without read", bus_rdata, 8'h00);
        bus_sel = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule